// File: doc/BRIEF.md
# Uncorrectable Error Logger with Capture Pointers

This block gathers uncorrectable error events raised inside a DMA cluster and holds them in sticky status bits until software clears them by writing ones. Every status bit has a mask bit and a severity bit beside it. The fatal and non-fatal indications are formed from the status bits that are set and unmasked, split by severity. Reporting these conditions upstream as messages is left to logic outside this block.

Two capture pointers help software find where to start looking. The first-error pointer records the index of the earliest unmasked error event. The global pointer records which of the channel error groups first showed an unmasked error. A pointer does not move on later events. It becomes free again only when the thing it points at has gone away. For the first-error pointer that means its status bit has been cleared. For the global pointer it means that channel's summary input has dropped.

All pins are plain level or pulse signals. Nothing crosses the block's edge as a stream, so there is no valid/ready handshake. The register port writes on a single-cycle strobe, and reads combinationally from the address.

Top module: `errlog_top`

## Requirements
- R1: After reset, status reads 0x0000, mask reads 0x0000, severity reads 0x0098 (bits 3, 4 and 7 fatal), both pointer registers read 0x0000, and both fatal and non-fatal outputs are low.
- R2: A pulse on `err_evt` bit 2, 3, 4, 7 or 10 sets that status bit (register address 0) one clock edge later, whether or not it is masked. The bit stays set until it is cleared. Pulses on any other `err_evt` bit change nothing.
- R3: Writing address 0 clears each status bit whose write-data bit is 1. Bits written with 0 keep their value. When an event sets a bit in the same cycle as a write clears it, the bit stays set.
- R4: Mask (address 1, 1 = masked) and severity (address 2, 1 = fatal) are read/write. Only bits 2, 3, 4, 7, 10 and 12 are stored, and all other bits read 0.
- R5: `err_fatal` is high when some status bit is set, unmasked and has severity 1. `err_nonfatal` is high when some status bit is set, unmasked and has severity 0. Both follow status, mask and severity with no added delay.
- R6: When the first-error pointer is free and unmasked events arrive, it captures the lowest-numbered one. Address 3 reads the index in bits 4:0 and a valid flag in bit 15. Valid is 1 only while the pointer is held and the named status bit is set and unmasked. Masked events are never captured.
- R7: A held first-error pointer ignores later events until its named status bit has been cleared. In the first cycle where that bit reads clear, the pointer is free, and an unmasked event in that cycle is captured.
- R8: Status bit 12 (multiple errors) sets when an unmasked event arrives while an unmasked source bit is already logged. It also sets when two or more unmasked events arrive in the same cycle.
- R9: The global pointer (address 4, channel in bits 3:0, held flag in bit 15) captures the lowest channel whose `chan_err` bit is high, if it is free. It holds while that channel's bit stays high. In the cycle that bit is low, the pointer is free and may capture again. When it is free with no channel high, it reads invalid and keeps the last index.
- R10: Addresses 5 to 7 read 0x0000, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_evt | input | 13 | Error event pulses, one bit per status position |
| chan_err | input | 8 | Per-channel summary: the channel has an unmasked error logged |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| err_fatal | output | 1 | Unmasked fatal error present |
| err_nonfatal | output | 1 | Unmasked non-fatal error present |

## Verification
Each event, write or summary change is registered on one clock edge. Its effect on status, mask, severity and either pointer therefore shows on the read port right after that edge. The fatal and non-fatal outputs follow in that same cycle, because they are combinational from those registers. The bench applies each stimulus for exactly one edge, then moves the read address a moment after the edge and samples a moment later, before the next falling edge. The pointer re-arm cases are stepped one edge at a time. This confirms that the release and a new capture take place on the same edge.

// File: rtl/errlog_pkg.sv
package errlog_pkg;
  localparam int ERR_W      = 13;
  localparam int NUM_CHAN   = 8;
  localparam int FPTR_W     = 5;
  localparam int GPTR_W     = 4;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 3;
  localparam int MULTI_IDX  = 12;
  localparam logic [ERR_W-1:0] SRC_BITS = 13'h049C;
  localparam logic [ERR_W-1:0] SEV_INIT = 13'h0098;

  typedef enum logic [ADDR_W-1:0] {
    A_STATUS = 3'd0,
    A_MASK   = 3'd1,
    A_SEV    = 3'd2,
    A_FPTR   = 3'd3,
    A_GPTR   = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/errlog_status.sv
module errlog_status #(
  parameter int               ERR_W     = 13,
  parameter int               MULTI_IDX = 12,
  parameter logic [ERR_W-1:0] SRC_BITS  = 13'h049C,
  parameter logic [ERR_W-1:0] SEV_INIT  = 13'h0098
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_W-1:0] evt,
  input  logic [ERR_W-1:0] clr,
  input  logic             mask_we,
  input  logic             sev_we,
  input  logic [ERR_W-1:0] wdata,
  output logic [ERR_W-1:0] status_q,
  output logic [ERR_W-1:0] mask_q,
  output logic [ERR_W-1:0] sev_q,
  output logic [ERR_W-1:0] unm_evt,
  output logic             fatal,
  output logic             nonfatal
);
  localparam logic [ERR_W-1:0] MULTI_BIT = ERR_W'(1) << MULTI_IDX;
  localparam logic [ERR_W-1:0] DEF_BITS  = SRC_BITS | MULTI_BIT;

  logic [ERR_W-1:0] src_evt, logged, set_vec, status_d;
  logic             multi_hit;

  always_comb begin
    src_evt   = evt & SRC_BITS;
    unm_evt   = src_evt & ~mask_q;
    logged    = status_q & SRC_BITS & ~mask_q;
    multi_hit = ((|unm_evt) && (|logged)) || ((unm_evt & (unm_evt - 1'b1)) != '0);
    set_vec   = src_evt | (multi_hit ? MULTI_BIT : '0);
    status_d  = ((status_q & ~clr) | set_vec) & DEF_BITS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
      sev_q    <= SEV_INIT & DEF_BITS;
    end else begin
      status_q <= status_d;
      if (mask_we) mask_q <= wdata & DEF_BITS;
      if (sev_we)  sev_q  <= wdata & DEF_BITS;
    end
  end

  assign fatal    = |(status_q & ~mask_q & sev_q);
  assign nonfatal = |(status_q & ~mask_q & ~sev_q);

  // R2: a set bit survives unless a clear was written for it
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status_q) & ~$past(clr)) & ~status_q) == '0));
  // R3: an event wins over a simultaneous clear
  p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_evt != '0) |=> ((status_q & $past(src_evt)) == $past(src_evt)));
  // R8: overlapping unmasked errors flag the multiple-errors bit
  p_multi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|unm_evt) && (|logged)) |=> status_q[MULTI_IDX]);
endmodule

// File: rtl/errlog_first_ptr.sv
module errlog_first_ptr #(
  parameter int ERR_W  = 13,
  parameter int FPTR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ERR_W-1:0]  unm_evt,
  input  logic [ERR_W-1:0]  status_q,
  input  logic [ERR_W-1:0]  mask_q,
  output logic [FPTR_W-1:0] ptr_q,
  output logic              valid
);
  logic              held_q, sel_set, sel_masked, free;
  logic [FPTR_W-1:0] low_idx;
  logic [ERR_W-1:0]  sel_onehot;

  always_comb begin
    low_idx = '0;
    for (int i = ERR_W - 1; i >= 0; i--)
      if (unm_evt[i]) low_idx = FPTR_W'(i);
  end

  assign sel_onehot = ERR_W'(1) << ptr_q;
  assign sel_set    = |(status_q & sel_onehot);
  assign sel_masked = |(mask_q & sel_onehot);
  assign free       = !held_q || !sel_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      ptr_q  <= '0;
    end else if (free) begin
      held_q <= |unm_evt;
      if (|unm_evt) ptr_q <= low_idx;
    end
  end

  assign valid = held_q && sel_set && !sel_masked;

  // R6: a free pointer takes an unmasked event
  p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (free && (|unm_evt)) |=> (held_q && (|(status_q & (ERR_W'(1) << ptr_q)))));
  // R7: a held pointer whose bit is still set does not move
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && sel_set) |=> (held_q && $stable(ptr_q)));
endmodule

// File: rtl/errlog_glb_ptr.sv
module errlog_glb_ptr #(
  parameter int NUM_CHAN = 8,
  parameter int GPTR_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CHAN-1:0] chan_err,
  output logic [GPTR_W-1:0] ptr_q,
  output logic              held_q
);
  logic              sel_on, free;
  logic [GPTR_W-1:0] low_idx;

  always_comb begin
    low_idx = '0;
    for (int i = NUM_CHAN - 1; i >= 0; i--)
      if (chan_err[i]) low_idx = GPTR_W'(i);
  end

  assign sel_on = |(chan_err & (NUM_CHAN'(1) << ptr_q));
  assign free   = !held_q || !sel_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      ptr_q  <= '0;
    end else if (free) begin
      held_q <= |chan_err;
      if (|chan_err) ptr_q <= low_idx;
    end
  end

  // R9: hold while the named channel stays in error
  p_glb_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && sel_on) |=> (held_q && $stable(ptr_q)));
  // R9: release when nothing is pending and the named channel cleared
  p_glb_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !sel_on && !(|chan_err)) |=> !held_q);
endmodule

// File: rtl/errlog_top.sv
module errlog_top
  import errlog_pkg::*;
#(
  parameter int               P_ERR_W     = ERR_W,
  parameter int               P_NUM_CHAN  = NUM_CHAN,
  parameter int               P_FPTR_W    = FPTR_W,
  parameter int               P_GPTR_W    = GPTR_W,
  parameter int               P_DATA_W    = DATA_W,
  parameter int               P_ADDR_W    = ADDR_W,
  parameter int               P_MULTI_IDX = MULTI_IDX,
  parameter logic [P_ERR_W-1:0] P_SRC_BITS = SRC_BITS,
  parameter logic [P_ERR_W-1:0] P_SEV_INIT = SEV_INIT
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [P_ERR_W-1:0]    err_evt,
  input  logic [P_NUM_CHAN-1:0] chan_err,
  input  logic                  reg_wr,
  input  logic [P_ADDR_W-1:0]   reg_addr,
  input  logic [P_DATA_W-1:0]   reg_wdata,
  output logic [P_DATA_W-1:0]   reg_rdata,
  output logic                  err_fatal,
  output logic                  err_nonfatal
);
  logic [P_ERR_W-1:0]  status_q, mask_q, sev_q, unm_evt, clr_vec, wbits;
  logic [P_FPTR_W-1:0] fptr;
  logic [P_GPTR_W-1:0] gptr;
  logic                fvalid, gheld, mask_we, sev_we;
  logic                unused_wdata;

  assign wbits        = reg_wdata[P_ERR_W-1:0];
  assign unused_wdata = ^reg_wdata[P_DATA_W-1:P_ERR_W];
  assign clr_vec      = (reg_wr && reg_addr == A_STATUS) ? wbits : '0;
  assign mask_we      = reg_wr && reg_addr == A_MASK;
  assign sev_we       = reg_wr && reg_addr == A_SEV;

  errlog_status #(
    .ERR_W(P_ERR_W), .MULTI_IDX(P_MULTI_IDX),
    .SRC_BITS(P_SRC_BITS), .SEV_INIT(P_SEV_INIT)
  ) u_status (
    .clk(clk), .rst_n(rst_n), .evt(err_evt), .clr(clr_vec),
    .mask_we(mask_we), .sev_we(sev_we), .wdata(wbits),
    .status_q(status_q), .mask_q(mask_q), .sev_q(sev_q),
    .unm_evt(unm_evt), .fatal(err_fatal), .nonfatal(err_nonfatal)
  );

  errlog_first_ptr #(.ERR_W(P_ERR_W), .FPTR_W(P_FPTR_W)) u_fptr (
    .clk(clk), .rst_n(rst_n), .unm_evt(unm_evt), .status_q(status_q),
    .mask_q(mask_q), .ptr_q(fptr), .valid(fvalid)
  );

  errlog_glb_ptr #(.NUM_CHAN(P_NUM_CHAN), .GPTR_W(P_GPTR_W)) u_gptr (
    .clk(clk), .rst_n(rst_n), .chan_err(chan_err), .ptr_q(gptr), .held_q(gheld)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STATUS: reg_rdata[P_ERR_W-1:0] = status_q;
      A_MASK:   reg_rdata[P_ERR_W-1:0] = mask_q;
      A_SEV:    reg_rdata[P_ERR_W-1:0] = sev_q;
      A_FPTR: begin
        reg_rdata[P_FPTR_W-1:0] = fptr;
        reg_rdata[P_DATA_W-1]   = fvalid;
      end
      A_GPTR: begin
        reg_rdata[P_GPTR_W-1:0] = gptr;
        reg_rdata[P_DATA_W-1]   = gheld;
      end
      default: reg_rdata = '0;
    endcase
  end

  // R5: no error indication without a set, unmasked status bit
  p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~mask_q) == '0) |-> (!err_fatal && !err_nonfatal));
endmodule

// File: tb/test_errlog_top.sv
module test_errlog_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] err_evt = '0;
  logic [7:0]  chan_err = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        err_fatal, err_nonfatal;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  errlog_top i_errlog_top (
    .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .chan_err(chan_err),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .err_fatal(err_fatal), .err_nonfatal(err_nonfatal)
  );

  typedef struct packed {
    logic [12:0] evt;
    logic [7:0]  chan;
    logic        wr;
    logic [2:0]  waddr;
    logic [15:0] wdata;
    logic [2:0]  raddr;
    logic [15:0] exp;
    logic        ef;
    logic        enf;
    logic [3:0]  req;
  } step_t;

  localparam int NSTEP = 22;
  localparam step_t TBL [NSTEP] = '{
    '{13'h0004, 8'h00, 1'b0, 3'd0, 16'h0000, 3'd0, 16'h0004, 1'b0, 1'b1, 4'd2},  // R2 R5
    '{13'h0000, 8'h00, 1'b0, 3'd0, 16'h0000, 3'd3, 16'h8002, 1'b0, 1'b1, 4'd6},  // R6
    '{13'h0008, 8'h00, 1'b0, 3'd0, 16'h0000, 3'd0, 16'h100C, 1'b1, 1'b1, 4'd8},  // R8
    '{13'h0000, 8'h00, 1'b0, 3'd0, 16'h0000, 3'd3, 16'h8002, 1'b1, 1'b1, 4'd7},  // R7
    '{13'h0000, 8'h00, 1'b1, 3'd0, 16'h0004, 3'd3, 16'h0002, 1'b1, 1'b1, 4'd3},  // R3 R6
    '{13'h0000, 8'h00, 1'b0, 3'd0, 16'h0000, 3'd0, 16'h1008, 1'b1, 1'b1, 4'd3},  // R3
    '{13'h0000, 8'h00, 1'b1, 3'd1, 16'hFFFF, 3'd1, 16'h149C, 1'b0, 1'b0, 4'd4},  // R4 R5
    '{13'h0080, 8'h00, 1'b0, 3'd0, 16'h0000, 3'd3, 16'h0002, 1'b0, 1'b0, 4'd6},  // R6
    '{13'h0000, 8'h00, 1'b1, 3'd1, 16'h0000, 3'd0, 16'h1088, 1'b1, 1'b1, 4'd5},  // R5
    '{13'h0000, 8'h00, 1'b1, 3'd2, 16'hFFFF, 3'd2, 16'h149C, 1'b1, 1'b0, 4'd4},  // R4 R5
    '{13'h0000, 8'h00, 1'b1, 3'd2, 16'h0000, 3'd2, 16'h0000, 1'b0, 1'b1, 4'd5},  // R5
    '{13'h0000, 8'h00, 1'b1, 3'd0, 16'hFFFF, 3'd0, 16'h0000, 1'b0, 1'b0, 4'd3},  // R3
    '{13'h0410, 8'h00, 1'b0, 3'd0, 16'h0000, 3'd3, 16'h8004, 1'b0, 1'b1, 4'd6},  // R6
    '{13'h0000, 8'h00, 1'b0, 3'd0, 16'h0000, 3'd0, 16'h1410, 1'b0, 1'b1, 4'd8},  // R8
    '{13'h0010, 8'h00, 1'b1, 3'd0, 16'h0010, 3'd0, 16'h1410, 1'b0, 1'b1, 4'd3},  // R3
    '{13'h0004, 8'h00, 1'b0, 3'd0, 16'h0000, 3'd3, 16'h8004, 1'b0, 1'b1, 4'd7},  // R7
    '{13'h0003, 8'h00, 1'b0, 3'd0, 16'h0000, 3'd0, 16'h1414, 1'b0, 1'b1, 4'd2},  // R2
    '{13'h0000, 8'h28, 1'b1, 3'd6, 16'hFFFF, 3'd4, 16'h8003, 1'b0, 1'b1, 4'd9},  // R9
    '{13'h0000, 8'h21, 1'b0, 3'd0, 16'h0000, 3'd4, 16'h8000, 1'b0, 1'b1, 4'd9},  // R9
    '{13'h0000, 8'h01, 1'b0, 3'd0, 16'h0000, 3'd4, 16'h8000, 1'b0, 1'b1, 4'd9},  // R9
    '{13'h0000, 8'h00, 1'b0, 3'd0, 16'h0000, 3'd4, 16'h0000, 1'b0, 1'b1, 4'd9},  // R9
    '{13'h0000, 8'h00, 1'b0, 3'd0, 16'h0000, 3'd6, 16'h0000, 1'b0, 1'b1, 4'd10}  // R10
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [15:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic step(input logic [12:0] e, input logic w, input logic [2:0] wa,
                      input logic [15:0] wd);
    @(negedge clk);
    err_evt = e; reg_wr = w; reg_addr = wa; reg_wdata = wd;
    @(posedge clk);
    #1;
    err_evt = '0; reg_wr = 1'b0;
  endtask

  initial begin
    #(10 * 100000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_chk("R1 status", 3'd0, 16'h0000);
    rd_chk("R1 mask", 3'd1, 16'h0000);
    rd_chk("R1 severity", 3'd2, 16'h0098);
    rd_chk("R1 first ptr", 3'd3, 16'h0000);
    rd_chk("R1 global ptr", 3'd4, 16'h0000);
    chk("R1 outputs", {14'd0, err_fatal, err_nonfatal}, 16'h0000);

    for (int k = 0; k < NSTEP; k++) begin
      @(negedge clk);
      err_evt = TBL[k].evt; chan_err = TBL[k].chan; reg_wr = TBL[k].wr;
      reg_addr = TBL[k].waddr; reg_wdata = TBL[k].wdata;
      @(posedge clk);
      #1;
      err_evt = '0; reg_wr = 1'b0;
      reg_addr = TBL[k].raddr;
      #1;
      chk($sformatf("R%0d step %0d read", TBL[k].req, k), reg_rdata, TBL[k].exp);
      chk($sformatf("R5 step %0d outputs", k), {14'd0, err_fatal, err_nonfatal},
          {14'd0, TBL[k].ef, TBL[k].enf});
    end
    // R10 write to unmapped address left status untouched
    rd_chk("R10 status after unmapped write", 3'd0, 16'h1414);

    // R1 reset in the middle of activity
    chan_err = 8'h10;
    step(13'h0008, 1'b0, 3'd0, 16'h0);
    @(negedge clk);
    chan_err = 8'h00;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd_chk("R1 status after reset", 3'd0, 16'h0000);
    rd_chk("R1 severity after reset", 3'd2, 16'h0098);
    rd_chk("R1 first ptr after reset", 3'd3, 16'h0000);
    rd_chk("R1 global ptr after reset", 3'd4, 16'h0000);

    // R6 simultaneous events, lowest one masked
    step(13'h0000, 1'b1, 3'd1, 16'h0004);
    step(13'h0484, 1'b0, 3'd0, 16'h0);
    rd_chk("R6 lowest unmasked wins", 3'd3, 16'h8007);
    rd_chk("R8 two at once", 3'd0, 16'h1484);
    chk("R5 fatal from bit 7", {15'd0, err_fatal}, 16'h0001);

    // R7 clear the pointed bit, then the next event captures at once
    step(13'h0000, 1'b1, 3'd0, 16'h0080);
    rd_chk("R7 cleared bit invalidates", 3'd3, 16'h0007);
    step(13'h0400, 1'b0, 3'd0, 16'h0);
    rd_chk("R7 recapture on re-arm", 3'd3, 16'h800A);

    // R6 masking the pointed bit drops valid but keeps index
    step(13'h0000, 1'b1, 3'd1, 16'h0400);
    rd_chk("R6 masked pointed bit", 3'd3, 16'h000A);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule